// File: doc/BRIEF.md
# Data-Object Mailbox Responder

This block is the device-side end of a configuration-space mailbox that moves data objects made of 32-bit words. A host reaches it through a small register port with one 32-bit register per address. The host writes a request one word at a time into a write-mailbox register, then sets a Go control bit. The block checks the request's header, streams the buffered words to a backend over a valid/ready word channel, and collects the backend's reply into a response buffer.

Once the reply is complete and its header is consistent, a ready flag rises. The host then reads the reply word by word through a read-mailbox register, writing to that register to move to the next word. The block also provides a busy flag, an error flag, an optional interrupt, and an abort control that returns the mailbox to a clean state from any point in an exchange.

Every data object starts with two header words. The first carries a 16-bit vendor code in bits 15:0 and an 8-bit object type in bits 23:16. The second carries the object's full length in words, both headers included, in bits 17:0.

Top module: `dobj_mbox`

## Requirements
- R1: After reset, the control register (offset 0x08) and the status register (offset 0x0C) both read 0, `irq` is 0, and neither `req_valid` nor `rsp_ready` is high.
- R2: The capability register at offset 0x04 reads the interrupt-supported flag in bit 0 and the interrupt message number in bits 11:1. All other bits read 0.
- R3: Words written to offset 0x10 while the mailbox is idle are buffered in order. A control write with bit 31 (Go) set streams them to `req_data` in the same order, with `req_last` high only on the final word. Status bit 0 (Busy) reads 1 from the Go write until the edge on which the final word is accepted.
- R4: A Go is refused in three cases: fewer than 2 words are buffered, the length field of word 2 is below 2, or more words were written than the buffer holds. A refused Go sets status bit 2 (Error), discards the request, sends no word to the backend and leaves Busy at 0.
- R5: The reply is collected while `rsp_ready` is high. Status bit 31 (Data Object Ready) rises on the second rising edge after the handshake that carries `rsp_last`. From then on, offset 0x14 reads the first reply word.
- R6: Reading offset 0x14 does not advance it. Each write to offset 0x14 moves to the next word. The write that acknowledges the last word clears Data Object Ready, after which offset 0x14 reads 0.
- R7: A reply is rejected in four cases: fewer than 2 words, a length field below 2, a length field larger than the number of words received, or more words than the buffer holds. A rejected reply sets Error, keeps Data Object Ready at 0 and is discarded.
- R8: Control bit 1 is Interrupt Enable. When it is 1, `irq` pulses high for one cycle and status bit 1 (Interrupt Status) sets on two events: Data Object Ready rising, or an abort. When it is 0, neither happens.
- R9: Writing status with bit 1 set clears Interrupt Status. Writing status with bit 1 clear leaves it unchanged.
- R10: A control write with bit 0 (Abort) set empties both buffers. Busy, Error and Data Object Ready all read 0 on the next cycle. Abort takes priority over Go in the same write, and the next request starts from an empty buffer.
- R11: While Error is set or an exchange is in progress, writes to offset 0x10 and Go writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Byte offset of the register accessed |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | output | 1 | A request word is offered to the backend |
| req_ready | input | 1 | The backend accepts the offered request word |
| req_data | output | 32 | Request word |
| req_last | output | 1 | The offered word is the final request word |
| rsp_valid | input | 1 | The backend offers a reply word |
| rsp_ready | output | 1 | The block is collecting reply words |
| rsp_data | input | 32 | Reply word |
| rsp_last | input | 1 | The offered reply word is the final one |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A register write takes effect on the rising edge that captures it, and register reads are combinational from state. The bench therefore drives each write at a falling edge and samples the result at the next falling edge. Busy falls on the edge that takes the last request word. Data Object Ready and the `irq` pulse appear two edges after the final reply handshake, because one cycle is spent checking the reply's length. The bench confirms the flag is still low one falling edge after that handshake and high one falling edge later. An abort's pulse is checked at the first falling edge after its write, and checked again at the following falling edge to confirm it has already dropped back to 0.

// File: rtl/dobj_mbox_pkg.sv
package dobj_mbox_pkg;

  localparam int unsigned OFS_CAP  = 32'h04;
  localparam int unsigned OFS_CTRL = 32'h08;
  localparam int unsigned OFS_STS  = 32'h0C;
  localparam int unsigned OFS_WMB  = 32'h10;
  localparam int unsigned OFS_RMB  = 32'h14;

  localparam int unsigned CTRL_ABORT = 0;
  localparam int unsigned CTRL_IE    = 1;
  localparam int unsigned CTRL_GO    = 31;

  localparam int unsigned STS_INT = 1;

  localparam int unsigned LEN_W = 18;

  typedef enum logic [2:0] {
    MB_IDLE,
    MB_SEND,
    MB_COLLECT,
    MB_CHECK,
    MB_PRESENT
  } mb_state_e;

endpackage

// File: rtl/dobj_wbuf.sv
module dobj_wbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int LW    = 18,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] len_field,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] rd_idx,
  output logic          full,
  output logic          ovf
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] fill_d;
  logic [CW-1:0] rd_d;
  logic          ovf_d;
  logic          wr_en;

  assign full  = (fill == CW'(DEPTH));
  assign wr_en = push && !full && !clr;

  always_comb begin
    fill_d = fill;
    rd_d   = rd_idx;
    ovf_d  = ovf;
    if (clr) begin
      fill_d = '0;
      rd_d   = '0;
      ovf_d  = 1'b0;
    end else begin
      if (wr_en)         fill_d = fill + CW'(1);
      if (push && full)  ovf_d  = 1'b1;
      if (pop)           rd_d   = rd_idx + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[fill[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill   <= '0;
      rd_idx <= '0;
      ovf    <= 1'b0;
    end else begin
      fill   <= fill_d;
      rd_idx <= rd_d;
      ovf    <= ovf_d;
    end
  end

  assign head      = mem_q[rd_idx[PW-1:0]];
  assign len_field = mem_q[1][LW-1:0];

  // A push into a full buffer must leave a sticky overflow mark (R4, R7).
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> ovf);

  // Words are only taken out when some are held (R3).
  assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (rd_idx < fill));

endmodule

// File: rtl/dobj_len_chk.sv
module dobj_len_chk #(
  parameter int CW          = 5,
  parameter int LW          = 18,
  parameter bit CHECK_SHORT = 1'b0
) (
  input  logic [CW-1:0] fill,
  input  logic [LW-1:0] len,
  input  logic          ovf,
  output logic          bad
);

  logic base_bad;

  assign base_bad = ovf || (fill < CW'(2)) || (len < LW'(2));

  generate
    if (CHECK_SHORT) begin : g_short
      assign bad = base_bad || (32'(len) > 32'(fill));
    end else begin : g_plain
      assign bad = base_bad;
    end
  endgenerate

endmodule

// File: rtl/dobj_mbox.sv
module dobj_mbox #(
  parameter int          DEPTH   = 16,
  parameter int          AW      = 8,
  parameter bit          IRQ_SUP = 1'b1,
  parameter logic [10:0] IRQ_MSG = 11'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [31:0]   req_data,
  output logic          req_last,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [31:0]   rsp_data,
  input  logic          rsp_last,
  output logic          irq
);
  import dobj_mbox_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  mb_state_e state_q, state_d;
  logic err_q, err_d;
  logic ie_q, ie_d;
  logic ists_q, ists_d;
  logic irq_d;

  logic wr_ctrl, wr_sts, wr_wmb, wr_rmb;
  logic abort_req, go_req, idle_ok, go_acc, go_ok, go_fail;
  logic chk_fail, evt, ack, ack_last;
  logic busy, dor;

  logic [31:0]      rq_head, rs_head;
  logic [LEN_W-1:0] rq_len, rs_len;
  logic [CW-1:0]    rq_fill, rq_rd, rs_fill, rs_rd;
  logic             rq_full, rs_full, rq_ovf, rs_ovf;
  logic             rq_push, rq_pop, rq_clr, rs_push, rs_pop, rs_clr;
  logic             req_bad, rsp_bad;

  // register decode
  assign wr_ctrl = reg_wr && (reg_addr == AW'(OFS_CTRL));
  assign wr_sts  = reg_wr && (reg_addr == AW'(OFS_STS));
  assign wr_wmb  = reg_wr && (reg_addr == AW'(OFS_WMB));
  assign wr_rmb  = reg_wr && (reg_addr == AW'(OFS_RMB));

  assign abort_req = wr_ctrl && reg_wdata[CTRL_ABORT];
  assign go_req    = wr_ctrl && reg_wdata[CTRL_GO] && !abort_req;
  assign idle_ok   = (state_q == MB_IDLE) && !err_q;
  assign go_acc    = go_req && idle_ok;
  assign go_ok     = go_acc && !req_bad;
  assign go_fail   = go_acc && req_bad;

  assign busy = (state_q == MB_SEND);
  assign dor  = (state_q == MB_PRESENT);

  // request path
  assign rq_push   = wr_wmb && idle_ok;
  assign req_valid = busy && (rq_rd < rq_fill);
  assign req_data  = rq_head;
  assign req_last  = (rq_rd == rq_fill - CW'(1));
  assign rq_pop    = req_valid && req_ready;
  assign rq_clr    = abort_req || go_fail || (rq_pop && req_last);

  dobj_wbuf #(.DEPTH(DEPTH), .W(32), .LW(LEN_W)) u_req_buf (
    .clk(clk), .rst_n(rst_n), .clr(rq_clr), .push(rq_push), .push_data(reg_wdata),
    .pop(rq_pop), .head(rq_head), .len_field(rq_len), .fill(rq_fill),
    .rd_idx(rq_rd), .full(rq_full), .ovf(rq_ovf)
  );

  dobj_len_chk #(.CW(CW), .LW(LEN_W), .CHECK_SHORT(1'b0)) u_req_chk (
    .fill(rq_fill), .len(rq_len), .ovf(rq_ovf), .bad(req_bad)
  );

  // response path
  assign rsp_ready = (state_q == MB_COLLECT);
  assign rs_push   = rsp_valid && rsp_ready;
  assign ack       = wr_rmb && dor;
  assign ack_last  = ack && (rs_rd == rs_fill - CW'(1));
  assign rs_pop    = ack && !ack_last;
  assign chk_fail  = (state_q == MB_CHECK) && rsp_bad;
  assign rs_clr    = abort_req || chk_fail || ack_last;

  dobj_wbuf #(.DEPTH(DEPTH), .W(32), .LW(LEN_W)) u_rsp_buf (
    .clk(clk), .rst_n(rst_n), .clr(rs_clr), .push(rs_push), .push_data(rsp_data),
    .pop(rs_pop), .head(rs_head), .len_field(rs_len), .fill(rs_fill),
    .rd_idx(rs_rd), .full(rs_full), .ovf(rs_ovf)
  );

  dobj_len_chk #(.CW(CW), .LW(LEN_W), .CHECK_SHORT(1'b1)) u_rsp_chk (
    .fill(rs_fill), .len(rs_len), .ovf(rs_ovf), .bad(rsp_bad)
  );

  // next state
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      MB_IDLE:    if (go_ok) state_d = MB_SEND;
      MB_SEND:    if (rq_pop && req_last) state_d = MB_COLLECT;
      MB_COLLECT: if (rs_push && rsp_last) state_d = MB_CHECK;
      MB_CHECK:   state_d = rsp_bad ? MB_IDLE : MB_PRESENT;
      MB_PRESENT: if (ack_last) state_d = MB_IDLE;
      default:    state_d = MB_IDLE;
    endcase
    if (go_fail || chk_fail) err_d = 1'b1;
    if (abort_req) begin
      state_d = MB_IDLE;
      err_d   = 1'b0;
    end
  end

  always_comb begin
    ie_d   = wr_ctrl ? (reg_wdata[CTRL_IE] & IRQ_SUP) : ie_q;
    evt    = abort_req || ((state_q == MB_CHECK) && !rsp_bad);
    irq_d  = evt && ie_d;
    ists_d = ists_q;
    if (wr_sts && reg_wdata[STS_INT]) ists_d = 1'b0;
    if (irq_d) ists_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MB_IDLE;
      err_q   <= 1'b0;
      ie_q    <= 1'b0;
      ists_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      ie_q    <= ie_d;
      ists_q  <= ists_d;
      irq     <= irq_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(OFS_CAP))
      reg_rdata = {20'd0, (IRQ_SUP ? IRQ_MSG : 11'd0), IRQ_SUP};
    else if (reg_addr == AW'(OFS_CTRL))
      reg_rdata = {30'd0, ie_q, 1'b0};
    else if (reg_addr == AW'(OFS_STS))
      reg_rdata = {dor, 28'd0, err_q, ists_q, busy};
    else if (reg_addr == AW'(OFS_RMB))
      reg_rdata = dor ? rs_head : 32'd0;
  end

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> ((state_q == MB_IDLE) && !err_q));

  assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_last) |=> (state_q != MB_SEND));

  assert_irq_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ists_q && ie_q));

  assert_dor_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_q == MB_PRESENT) |-> $past(wr_rmb || abort_req));

  assert_no_send_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !req_valid);

endmodule

// File: tb/dobj_mbox_tb_top.sv
module dobj_mbox_tb_top;

  localparam int          DEPTH = 16;
  localparam logic [10:0] MSG   = 11'd9;
  localparam logic [7:0]  A_CAP = 8'h04, A_CTL = 8'h08, A_STS = 8'h0C, A_WMB = 8'h10, A_RMB = 8'h14;
  localparam logic [31:0] HDR1  = 32'h0001_1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_last, rsp_ready, irq;
  logic        req_ready = 1'b0;
  logic [31:0] req_data;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_last = 1'b0;

  always #10 clk = ~clk;

  dobj_mbox #(.DEPTH(DEPTH), .AW(8), .IRQ_SUP(1'b1), .IRQ_MSG(MSG)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_last(req_last), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] cap_w [64];
  logic        cap_l [64];
  int          cap_n = 0;
  logic [31:0] qw [20];
  logic [31:0] rw [20];

  always @(posedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      cap_w[cap_n % 64] <= req_data;
      cap_l[cap_n % 64] <= req_last;
      cap_n <= cap_n + 1;
    end
  end

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load_req(input int n, input logic [31:0] len);
    for (int i = 0; i < n; i++) begin
      qw[i] = (i == 0) ? HDR1 : (i == 1) ? len : 32'hA500_0000 + i;
      wr(A_WMB, qw[i]);
    end
  endtask

  task automatic stream_req(input int n);
    req_ready = 1'b1;
    repeat (n) @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic send_rsp(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = rw[i]; rsp_last = (i == n - 1);
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STS, d); ck("R1 status after reset", d, 32'h0);
    rd(A_CTL, d); ck("R1 control after reset", d, 32'h0);
    ck("R1 irq/req_valid/rsp_ready low", {29'd0, irq, req_valid, rsp_ready}, 32'h0);
    rd(A_CAP, d); ck("R2 capability", d, {20'd0, MSG, 1'b1});
  endtask

  task automatic t_request();
    logic [31:0] d;
    int base;
    base = cap_n;
    load_req(4, 32'd4);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, d); ck("R3 busy after go", d, 32'h1);
    rd(A_CTL, d); ck("R8 IE reads back", d, 32'h2);
    stream_req(4);
    ck("R3 word count", cap_n - base, 32'd4);
    for (int i = 0; i < 4; i++) begin
      ck("R3 word order", cap_w[base + i], qw[i]);
      ck("R3 last flag", {31'd0, cap_l[base + i]}, {31'd0, (i == 3)});
    end
    rd(A_STS, d); ck("R3 busy drops", d, 32'h0);
  endtask

  task automatic t_response();
    logic [31:0] d;
    rw[0] = HDR1; rw[1] = 32'd3; rw[2] = 32'hCAFE_F00D;
    send_rsp(3);
    rd(A_STS, d); ck("R5 ready not yet set", d, 32'h0);
    @(negedge clk);
    rd(A_STS, d); ck("R5 ready set", d, 32'h8000_0002);
    ck("R8 irq on ready", {31'd0, irq}, 32'h1);
    rd(A_RMB, d); ck("R5 first reply word", d, HDR1);
    rd(A_RMB, d); ck("R6 read does not advance", d, HDR1);
    @(negedge clk);
    ck("R8 irq single cycle", {31'd0, irq}, 32'h0);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, d); ck("R11 go ignored while presenting", d, 32'h8000_0002);
    wr(A_RMB, 32'h0);
    rd(A_RMB, d); ck("R6 advance to word 2", d, 32'd3);
    wr(A_RMB, 32'h0);
    rd(A_RMB, d); ck("R6 advance to word 3", d, 32'hCAFE_F00D);
    wr(A_RMB, 32'h0);
    rd(A_STS, d); ck("R6 ready drops after last ack", d, 32'h2);
    rd(A_RMB, d); ck("R6 read mailbox empty", d, 32'h0);
    wr(A_STS, 32'h0);
    rd(A_STS, d); ck("R9 write 0 keeps int status", d, 32'h2);
    wr(A_STS, 32'h2);
    rd(A_STS, d); ck("R9 write 1 clears int status", d, 32'h0);
  endtask

  task automatic t_bad_req();
    logic [31:0] d;
    int base;
    base = cap_n;
    load_req(1, 32'd0);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, d); ck("R4 one-word request errors", d, 32'h4);
    load_req(4, 32'd4);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, d); ck("R11 go ignored under error", d, 32'h4);
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    req_ready = 1'b0;
    ck("R4 nothing sent", cap_n - base, 32'd0);
    wr(A_CTL, 32'h0000_0003);
    ck("R8 irq on abort", {31'd0, irq}, 32'h1);
    rd(A_STS, d); ck("R10 abort clears error", d, 32'h2);
    wr(A_STS, 32'h2);
    load_req(2, 32'd1);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, d); ck("R4 length below 2 errors", d, 32'h4);
    wr(A_CTL, 32'h0000_0003);
    wr(A_STS, 32'h2);
    load_req(DEPTH + 1, DEPTH + 1);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, d); ck("R4 request overflow errors", d, 32'h4);
    wr(A_CTL, 32'h0000_0003);
    wr(A_STS, 32'h2);
    base = cap_n;
    load_req(3, 32'd3);
    wr(A_CTL, 32'h8000_0000);
    stream_req(3);
    ck("R10 buffer empty after abort", cap_n - base, 32'd3);
    ck("R10 first word is new header", cap_w[base], HDR1);
  endtask

  task automatic t_bad_rsp();
    logic [31:0] d;
    rw[0] = HDR1; rw[1] = 32'd6; rw[2] = 32'h1111_2222;
    send_rsp(3);
    @(negedge clk);
    rd(A_STS, d); ck("R7 short reply errors", d, 32'h4);
    ck("R8 no irq with IE=0", {31'd0, irq}, 32'h0);
    wr(A_CTL, 32'h0000_0001);
    ck("R8 abort without IE gives no irq", {31'd0, irq}, 32'h0);
    rd(A_STS, d); ck("R10 status clean after abort", d, 32'h0);
    load_req(3, 32'd3);
    wr(A_CTL, 32'h8000_0000);
    stream_req(3);
    for (int i = 0; i < DEPTH + 1; i++) rw[i] = (i == 0) ? HDR1 : (i == 1) ? DEPTH + 1 : i;
    send_rsp(DEPTH + 1);
    @(negedge clk);
    rd(A_STS, d); ck("R7 reply overflow errors", d, 32'h4);
    wr(A_CTL, 32'h0000_0001);
  endtask

  task automatic t_abort_mid();
    logic [31:0] d;
    load_req(3, 32'd3);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, d); ck("R3 busy held while backend stalls", d, 32'h1);
    wr(A_CTL, 32'h8000_0003);
    rd(A_STS, d); ck("R10 abort mid-send clears busy", d, 32'h2);
    ck("R10 no word offered after abort", {31'd0, req_valid}, 32'h0);
    wr(A_STS, 32'h2);
  endtask

  task automatic t_noirq();
    logic [31:0] d;
    load_req(3, 32'd3);
    wr(A_CTL, 32'h8000_0000);
    stream_req(3);
    rw[0] = HDR1; rw[1] = 32'd3; rw[2] = 32'h5555_AAAA;
    send_rsp(3);
    @(negedge clk);
    rd(A_STS, d); ck("R8 ready without int status", d, 32'h8000_0000);
    ck("R8 no irq on ready with IE=0", {31'd0, irq}, 32'h0);
    repeat (3) wr(A_RMB, 32'h0);
    rd(A_STS, d); ck("R6 idle after acks", d, 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_request();
    t_response();
    t_bad_req();
    t_bad_rsp();
    t_abort_mid();
    t_noirq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule